// File: doc/BRIEF.md
# Keyboard Matrix Row/Column Scanner

This block connects a processor to a keyboard laid out as a matrix of five rows by eight columns. Software chooses which columns to drive by writing an active-low column register: a column is driven when its bit is 0. The block senses the five row lines and stores them in an active-low row latch. A row bit reads 0 when at least one closed key in that row sits on a driven column. Software can scan the matrix one column at a time, or drive several columns at once and use the row latch as a quick "any key down" test. The block has no scan sequencer and no debouncing. Software sets the scan rate and filters bounce.

The block shares a 16-bit register bus with a GPIO bank and decodes only its own four offsets. It raises a keyboard interrupt level whenever the row latch shows any row pulled low. The interrupt has a one-bit mask and is also gated by a functional clock-enable input.

The row latch is re-evaluated after any of these events:
- a column write;
- a mask write;
- a change in the synchronized key state;
- a rising edge of the clock enable.

Between events the row latch holds its value.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset the row latch reads 0x1F, the column register reads 0xFF, the mask reads 0, the status reads 0 and `kbd_irq` is low.
- R2: A write to offset 0x14 stores the low 8 bits of the write data as the column register. A read of 0x14 returns them, with bits 15:8 reading 0.
- R3: A write to offset 0x28 stores only bit 0 as the interrupt mask. A read of 0x28 returns that bit, with bits 15:1 reading 0.
- R4: Row latch bit r (read at offset 0x10, bits 4:0) is 0 exactly when some key input `keys[r*8+c]` is 1 and column register bit c is 0. Otherwise the bit is 1.
- R5: After a column write at a rising edge, the row latch still shows its old value until the next rising edge. From that edge on it shows the value for the new column setting. Without a re-evaluation event the row latch does not change.
- R6: Key inputs pass through a two-stage synchronizer. A key change made between edges appears in the row latch after the fourth rising edge that follows, and not before.
- R7: A read of offset 0x20 returns 1 in bit 0 when the row latch differs from 0x1F and the mask is 0. Otherwise it returns 0. Bits 15:1 read 0.
- R8: `kbd_irq` equals the 0x20 status bit while `clk_en` is high and is 0 while `clk_en` is low.
- R9: Writes to the read-only offsets 0x10 and 0x20 have no effect. Reads of any offset other than 0x10, 0x14, 0x20 and 0x28 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Functional clock enable; gates the interrupt, and its rising edge triggers re-evaluation |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address while `bus_sel` is high and `bus_we` is low |
| keys | input | 40 | Key closures, bit r*8+c is 1 while the key at row r, column c is pressed |
| kbd_irq | output | 1 | Keyboard interrupt level |

## Verification
Register contents, the mask and the status change in the same cycle as the write edge, so the bench reads them at the falling edge that follows. The row latch lags a column or mask write by one edge. The bench reads the old value just after the write edge and the new value one edge later. A key change needs four rising edges: two synchronizer stages, the snapshot register and the row latch. The bench applies keys at a falling edge and checks that the latch is unchanged after three edges and updated after the fourth. In the random phase the bench waits six edges before it compares the row latch, status and `kbd_irq` with values computed by its own functions.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

  // Register byte offsets on the shared bus
  localparam int unsigned OFF_ROWS = 'h10;
  localparam int unsigned OFF_COL  = 'h14;
  localparam int unsigned OFF_STAT = 'h20;
  localparam int unsigned OFF_MASK = 'h28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROWS,
    SEL_COL,
    SEL_STAT,
    SEL_MASK
  } kbd_sel_e;

endpackage

// File: rtl/kbd_key_sync.sv
module kbd_key_sync #(
  parameter int NKEYS  = 40,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKEYS-1:0] keys_in,
  output logic [NKEYS-1:0] keys_snap,
  output logic             key_chg
);

  logic [NKEYS-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= keys_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  // Snapshot used by the evaluator; a mismatch marks a key event
  assign key_chg = (stg[STAGES-1] != keys_snap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keys_snap <= '0;
    else        keys_snap <= stg[STAGES-1];
  end

endmodule

// File: rtl/kbd_row_eval.sv
module kbd_row_eval #(
  parameter int NR = 5,
  parameter int NC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_req,
  input  logic [NC-1:0]    col_q,
  input  logic [NR*NC-1:0] keys_snap,
  output logic [NR-1:0]    row_latch,
  output logic             eval_pend
);

  logic [NR-1:0] row_next;

  generate
    for (genvar r = 0; r < NR; r++) begin : g_row
      // low when a closed key meets a driven (zero) column
      assign row_next[r] = ~|(keys_snap[r*NC +: NC] & ~col_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_pend <= 1'b0;
      row_latch <= '1;
    end else begin
      eval_pend <= eval_req;
      if (eval_pend) row_latch <= row_next;
    end
  end

endmodule

// File: rtl/kbd_scan_regs.sv
module kbd_scan_regs
  import kbd_scan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NR     = 5,
  parameter int NC     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NR-1:0]     row_latch,
  input  logic              status,
  output logic [NC-1:0]     col_q,
  output logic              mask_q,
  output logic              col_wr,
  output logic              mask_wr,
  output logic [DATA_W-1:0] bus_rdata
);

  kbd_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFF_ROWS))      sel = SEL_ROWS;
    else if (bus_addr == ADDR_W'(OFF_COL))  sel = SEL_COL;
    else if (bus_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (bus_addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
  end

  assign col_wr  = bus_sel && bus_we && (sel == SEL_COL);
  assign mask_wr = bus_sel && bus_we && (sel == SEL_MASK);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:NC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '1;
      mask_q <= 1'b0;
    end else begin
      if (col_wr)  col_q  <= bus_wdata[NC-1:0];
      if (mask_wr) mask_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (sel)
        SEL_ROWS: bus_rdata[NR-1:0] = row_latch;
        SEL_COL:  bus_rdata[NC-1:0] = col_q;
        SEL_STAT: bus_rdata[0]      = status;
        SEL_MASK: bus_rdata[0]      = mask_q;
        default:  bus_rdata         = '0;
      endcase
    end
  end

endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int NR          = 5,
  parameter int NC          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NR*NC-1:0]  keys,
  output logic              kbd_irq
);

  localparam int NKEYS = NR * NC;

  logic [NC-1:0]    col_q;
  logic             mask_q;
  logic             col_wr;
  logic             mask_wr;
  logic [NKEYS-1:0] keys_snap;
  logic             key_chg;
  logic [NR-1:0]    row_latch;
  logic             eval_pend;
  logic             en_q;
  logic             status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= clk_en;
  end

  assign status  = (row_latch != '1) && !mask_q;
  assign kbd_irq = clk_en && status;

  kbd_scan_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NR(NR), .NC(NC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .row_latch (row_latch),
    .status    (status),
    .col_q     (col_q),
    .mask_q    (mask_q),
    .col_wr    (col_wr),
    .mask_wr   (mask_wr),
    .bus_rdata (bus_rdata)
  );

  kbd_key_sync #(
    .NKEYS(NKEYS), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .keys_in   (keys),
    .keys_snap (keys_snap),
    .key_chg   (key_chg)
  );

  kbd_row_eval #(
    .NR(NR), .NC(NC)
  ) u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_req  (col_wr | mask_wr | key_chg | (clk_en & ~en_q)),
    .col_q     (col_q),
    .keys_snap (keys_snap),
    .row_latch (row_latch),
    .eval_pend (eval_pend)
  );

endmodule

// File: rtl/kbd_matrix_scan_chk.sv
module kbd_matrix_scan_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NR     = 5,
  parameter int NC     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kbd_irq,
  input logic [NR-1:0]     row_latch,
  input logic [NC-1:0]     col_q,
  input logic              mask_q,
  input logic              eval_pend
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (row_latch == '1) && (col_q == '1) && !mask_q && !kbd_irq);

  p_col_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'('h14)) |=> col_q == $past(bus_wdata[NC-1:0]));

  p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'('h28)) |=> mask_q == $past(bus_wdata[0]));

  p_rows_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_pend |=> $stable(row_latch));

  p_status_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == ADDR_W'('h20)) |->
      bus_rdata == DATA_W'((row_latch != '1) && !mask_q));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> clk_en && (row_latch != '1) && !mask_q);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !kbd_irq);

endmodule

bind kbd_matrix_scan kbd_matrix_scan_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NR(NR), .NC(NC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .kbd_irq   (kbd_irq),
  .row_latch (row_latch),
  .col_q     (col_q),
  .mask_q    (mask_q),
  .eval_pend (eval_pend)
);

// File: tb/kbd_matrix_scan_tb_top.sv
`timescale 1ns/1ps
module kbd_matrix_scan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [39:0] keys = '0;
  logic        kbd_irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0]  m_col;
  logic        m_mask;
  logic [15:0] rd;

  always #10 clk = ~clk;

  kbd_matrix_scan dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .keys(keys), .kbd_irq(kbd_irq)
  );

  function automatic logic [4:0] exp_rows(input logic [39:0] k, input logic [7:0] c);
    logic [4:0] res = 5'h1F;
    for (int r = 0; r < 5; r++)
      for (int cc = 0; cc < 8; cc++)
        if (k[r*8+cc] && !c[cc]) res[r] = 1'b0;
    return res;
  endfunction

  function automatic logic exp_stat(input logic [4:0] rows, input logic msk);
    return (rows != 5'h1F) && !msk;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_col = 8'hFF; m_mask = 1'b0;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(2);

    // R1 reset state
    bus_read(8'h10, rd); check("R1 rows", rd, 16'h001F);
    bus_read(8'h14, rd); check("R1 col", rd, 16'h00FF);
    bus_read(8'h28, rd); check("R1 mask", rd, 16'h0000);
    bus_read(8'h20, rd); check("R1 status", rd, 16'h0000);
    check("R1 irq", {15'd0, kbd_irq}, 16'h0000);

    // R2 column register width
    bus_write(8'h14, 16'h12F5); m_col = 8'hF5;
    bus_read(8'h14, rd); check("R2 col readback", rd, 16'h00F5);

    // R3 mask keeps bit 0 only
    bus_write(8'h28, 16'hFFFE);
    bus_read(8'h28, rd); check("R3 mask even", rd, 16'h0000);
    bus_write(8'h28, 16'h0003); m_mask = 1'b1;
    bus_read(8'h28, rd); check("R3 mask odd", rd, 16'h0001);
    bus_write(8'h28, 16'h0000); m_mask = 1'b0;

    // R6 key latency: key (2,3) pressed, column 3 driven by 0xF5? bit3=0 -> yes
    bus_write(8'h14, 16'h00F7); m_col = 8'hF7;
    wait_edges(2);
    @(negedge clk); keys = 40'd0; keys[2*8+3] = 1'b1;
    wait_edges(3);
    bus_read(8'h10, rd); check("R6 rows before 4th edge", rd, 16'h001F);
    wait_edges(1);
    bus_read(8'h10, rd); check("R6 rows after 4th edge", rd, {11'd0, exp_rows(keys, m_col)});
    bus_read(8'h20, rd); check("R7 status key down", rd, 16'h0001);
    check("R8 irq key down", {15'd0, kbd_irq}, 16'h0001);

    // R5 column-write latency
    bus_write(8'h14, 16'h00FF); m_col = 8'hFF;
    bus_read(8'h10, rd); check("R5 rows old after write", rd, 16'h001B);
    wait_edges(1);
    bus_read(8'h10, rd); check("R5 rows new one edge later", rd, 16'h001F);

    // R9 writes to read-only offsets, unmapped read
    bus_write(8'h14, 16'h0000); m_col = 8'h00;
    wait_edges(2);
    bus_write(8'h10, 16'h0000);
    bus_write(8'h20, 16'h0000);
    wait_edges(1);
    bus_read(8'h10, rd); check("R9 rows unchanged by write", rd, 16'h001B);
    bus_read(8'h20, rd); check("R9 status unchanged by write", rd, 16'h0001);
    bus_read(8'h3C, rd); check("R9 unmapped read", rd, 16'h0000);
    bus_read(8'h24, rd); check("R9 gpio offset read", rd, 16'h0000);

    // R8 clock enable gating and R7 mask
    @(negedge clk); clk_en = 1'b0;
    #1 check("R8 irq gated low", {15'd0, kbd_irq}, 16'h0000);
    bus_read(8'h20, rd); check("R7 status with enable low", rd, 16'h0001);
    bus_write(8'h28, 16'h0001); m_mask = 1'b1;
    @(negedge clk); clk_en = 1'b1;
    wait_edges(2);
    check("R8 irq masked", {15'd0, kbd_irq}, 16'h0000);
    bus_read(8'h20, rd); check("R7 status masked", rd, 16'h0000);

    // Random phase
    for (int it = 0; it < 60; it++) begin
      logic [39:0] k = '0;
      int nk = $urandom_range(0, 3);
      for (int j = 0; j < nk; j++) k[$urandom_range(0, 39)] = 1'b1;
      @(negedge clk);
      keys = k;
      clk_en = $urandom_range(0, 1) != 0;
      m_col = 8'($urandom);
      if ($urandom_range(0, 3) == 0) m_col = 8'hFF;
      m_mask = ($urandom_range(0, 3) == 0);
      bus_write(8'h14, {8'($urandom), m_col});
      bus_write(8'h28, {15'($urandom), m_mask});
      wait_edges(6);
      bus_read(8'h10, rd);
      check("R4 random rows", rd, {11'd0, exp_rows(keys, m_col)});
      bus_read(8'h20, rd);
      check("R7 random status", rd, {15'd0, exp_stat(exp_rows(keys, m_col), m_mask)});
      check("R8 random irq", {15'd0, kbd_irq},
            {15'd0, clk_en & exp_stat(exp_rows(keys, m_col), m_mask)});
    end

    finished = 1'b1;
    finish_run();
  end

endmodule